// File: doc/BRIEF.md
# Single-Error-Correcting Feedthrough Memory Checker

This block sits on the data path between a processor and a protected memory. It has no clock and no state. The processor side carries 16 data bits plus one parity bit. The memory side carries the same 17 bits plus 6 check bits.

On a write, the data and parity go straight through to the memory side, and the block produces the check bits. On a read, it recomputes the check groups over the word that came back from memory, forms a 6-bit syndrome and repairs a single flipped data bit when repair is enabled. Two active-low outputs report correctable and uncorrectable faults.

Three chip selects and a read/write strobe decide which side drives. The tri-state buffers are modelled as two output-enable outputs, one for the processor bus and one for the memory bus. The block is selected only when `sel_a_n_i` is low, `sel_b_n_i` is low and `sel_c_i` is high.

Top module: `edac_feedthru`

## Requirements
- R1: Bit 16 of each bus is parity. It is copied unchanged in both directions: memory bit 16 goes to `proc_data_o[16]`, and processor bit 16 goes to `mem_data_o[16]`. It is never checked or changed.
- R2: On the write side, `mem_data_o[15:0]` equals `proc_data_i[15:0]`. Check bit j is the XOR of the data bits in group j, inverted when j is 2 or 3 (odd groups). Data bit i belongs to group j when bit j of column C(i) is set. C(i) is the i-th value, in ascending numeric order, of the 6-bit values with exactly three ones, leaving out 7, 25, 38 and 56.
- R3: Syndrome bit j is the parity of group j over the memory data, together with memory check bit j and the same odd inversion as R2. A clean word gives syndrome 0 and both flags high. One flipped data bit gives a weight-3 syndrome, and one flipped check bit gives a weight-1 syndrome. In both cases the correctable flag `fix_err_n_o` goes low and `hard_err_n_o` stays high.
- R4: With `fix_en_i` high, a syndrome equal to C(i) inverts data bit i on `proc_data_o`, so a single data-bit fault reaches the processor corrected. No other bit changes.
- R5: With `fix_en_i` low, `proc_data_o[15:0]` equals `mem_data_i[15:0]` whatever the syndrome.
- R6: Any two flipped bits among the 22 code bits drive `hard_err_n_o` low and leave `fix_err_n_o` high.
- R7: When `flag_en_i` is low, or the device is not selected, `fix_err_n_o` is high and `hard_err_n_o` follows `ext_fault_n_i`.
- R8: A low `ext_fault_n_i` forces `hard_err_n_o` low, whatever the flag enable, the selects or the syndrome.
- R9: `proc_oe_o` is high only when the device is selected and `rd_not_wr_i` is high. `mem_oe_o` is high only when the device is selected and `rd_not_wr_i` is low. The two are never high together.
- R10: Flags are not masked on writes. A memory-side fault seen during a write drives the flags exactly as it would on a read.
- R11: A weight-3 syndrome that matches no column, for example three flipped check bits, drives both flags low and leaves the data uncorrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| proc_data_i | input | 17 | Processor bus data as seen by the block (bit 16 parity) |
| mem_data_i | input | 17 | Memory bus data as seen by the block (bit 16 parity) |
| mem_chk_i | input | 6 | Memory check-bit bus as seen by the block |
| rd_not_wr_i | input | 1 | High for read, low for write |
| sel_a_n_i | input | 1 | Active-low select |
| sel_b_n_i | input | 1 | Active-low select |
| sel_c_i | input | 1 | Active-high select |
| fix_en_i | input | 1 | High enables data repair |
| flag_en_i | input | 1 | High enables the error flags |
| ext_fault_n_i | input | 1 | Active-low external fault, fed to the uncorrectable flag |
| proc_data_o | output | 17 | Repaired data plus parity toward the processor |
| proc_oe_o | output | 1 | Processor bus drive enable |
| mem_data_o | output | 17 | Data plus parity toward the memory |
| mem_chk_o | output | 6 | Generated check bits toward the memory |
| mem_oe_o | output | 1 | Memory and check-bit bus drive enable |
| fix_err_n_o | output | 1 | Active-low correctable-fault flag |
| hard_err_n_o | output | 1 | Active-low uncorrectable-fault flag |

## Verification
The bench sweeps every 16-bit write value against an arithmetic model of the check code. A single wrong group member or a missing odd inversion shows up there as a wrong check bit.

It flips every one of the 22 code bits singly on a range of words, and every pair of bits on a few words. A swapped column in the correction decoder would then repair the wrong bit, and a mis-classed weight would raise the wrong flag.

Three-bit check faults that hit the four unused weight-3 patterns are aimed at a decoder that treats every weight-3 syndrome as correctable. A full sweep of the selects, the direction, the flag enable and the external fault catches flags that are masked on writes, or an external fault that wrongly depends on the selects.

// File: rtl/edac_pkg.sv
package edac_pkg;

   // Width of the code this package describes.
   localparam int CODE_CHK_W    = 6;
   localparam int CODE_MAX_DATA = 16;

   // Groups that use odd parity (bits 2 and 3).
   localparam logic [5:0] ODD_GROUPS_DEF = 6'b001100;

   function automatic int unsigned ones6(input logic [5:0] v);
      int unsigned n;
      n = 0;
      for (int k = 0; k < 6; k++) n = n + {31'd0, v[k]};
      return n;
   endfunction

   // Two complement pairs of weight-3 codes are left unused. This leaves
   // sixteen columns in which every group covers exactly eight data bits.
   function automatic logic is_spare(input logic [5:0] m);
      return (m == 6'd7) || (m == 6'd56) || (m == 6'd25) || (m == 6'd38);
   endfunction

   // Column code of data bit idx.
   function automatic logic [5:0] code_col(input int unsigned idx);
      logic [5:0]  m;
      int unsigned seen;
      code_col = '0;
      seen     = 0;
      for (int unsigned v = 0; v < 64; v++) begin
         m = v[5:0];
         if (ones6(m) == 3 && !is_spare(m)) begin
            if (seen == idx) code_col = m;
            seen++;
         end
      end
   endfunction

   // Data bits covered by group j.
   function automatic logic [15:0] group_mask(input int unsigned j);
      logic [5:0] c;
      group_mask = '0;
      for (int unsigned i = 0; i < 16; i++) begin
         c = code_col(i);
         group_mask[i] = c[j[2:0]];
      end
   endfunction

endpackage

// File: rtl/edac_chkgen.sv
module edac_chkgen #(
   parameter int         DATA_W   = 16,
   parameter int         CHK_W    = 6,
   parameter logic [5:0] ODD_MASK = edac_pkg::ODD_GROUPS_DEF
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CHK_W-1:0]  chk_o
);
   for (genvar j = 0; j < CHK_W; j++) begin : g_grp
      localparam logic [DATA_W-1:0] GM = DATA_W'(edac_pkg::group_mask(j));
      assign chk_o[j] = (^(data_i & GM)) ^ ODD_MASK[j];
   end
endmodule

// File: rtl/edac_syndrome.sv
module edac_syndrome #(
   parameter int         DATA_W     = 16,
   parameter int         CHK_W      = 6,
   parameter logic [5:0] ODD_MASK   = edac_pkg::ODD_GROUPS_DEF,
   parameter bit         SHARED_GEN = 1'b1
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [CHK_W-1:0]  chk_i,
   output logic [CHK_W-1:0]  syn_o
);
   if (SHARED_GEN) begin : g_shared
      // Regenerate the check bits and compare them with the stored ones.
      logic [CHK_W-1:0] regen;
      edac_chkgen #(.DATA_W(DATA_W), .CHK_W(CHK_W), .ODD_MASK(ODD_MASK)) u_regen (
         .data_i (data_i),
         .chk_o  (regen)
      );
      assign syn_o = regen ^ chk_i;
   end else begin : g_flat
      // One flat parity tree per group, check bit included.
      for (genvar j = 0; j < CHK_W; j++) begin : g_tree
         localparam logic [DATA_W-1:0] GM = DATA_W'(edac_pkg::group_mask(j));
         assign syn_o[j] = (^{data_i & GM, chk_i[j]}) ^ ODD_MASK[j];
      end
   end
endmodule

// File: rtl/edac_corrector.sv
module edac_corrector #(
   parameter int DATA_W = 16,
   parameter int CHK_W  = 6
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [CHK_W-1:0]  syn_i,
   input  logic              fix_en_i,
   output logic [DATA_W-1:0] data_o,
   output logic              col_hit_o
);
   logic [DATA_W-1:0] hit;

   for (genvar i = 0; i < DATA_W; i++) begin : g_col
      localparam logic [CHK_W-1:0] COL = CHK_W'(edac_pkg::code_col(i));
      assign hit[i] = (syn_i == COL);
   end

   assign data_o    = data_i ^ (hit & {DATA_W{fix_en_i}});
   assign col_hit_o = |hit;
endmodule

// File: rtl/edac_flags.sv
module edac_flags #(
   parameter int CHK_W = 6
) (
   input  logic [CHK_W-1:0] syn_i,
   input  logic             col_hit_i,
   input  logic             flag_on_i,
   input  logic             ext_fault_n_i,
   output logic             fix_err_n_o,
   output logic             hard_err_n_o
);
   localparam int WT_W = $clog2(CHK_W + 1);

   logic [WT_W-1:0] wt;
   logic            w_one, w_three, is_fix, is_hard;

   always_comb begin
      wt = '0;
      for (int k = 0; k < CHK_W; k++) wt = wt + WT_W'(syn_i[k]);
   end

   assign w_one   = (wt == WT_W'(1));
   assign w_three = (wt == WT_W'(3));
   assign is_fix  = w_one | w_three;
   assign is_hard = (wt != '0) & ~w_one & ~(w_three & col_hit_i);

   assign fix_err_n_o  = ~(flag_on_i & is_fix);
   assign hard_err_n_o = ~((flag_on_i & is_hard) | ~ext_fault_n_i);
endmodule

// File: rtl/edac_busctl.sv
module edac_busctl (
   input  logic sel_a_n_i,
   input  logic sel_b_n_i,
   input  logic sel_c_i,
   input  logic rd_not_wr_i,
   output logic selected_o,
   output logic proc_oe_o,
   output logic mem_oe_o
);
   assign selected_o = ~sel_a_n_i & ~sel_b_n_i & sel_c_i;
   assign proc_oe_o  = selected_o & rd_not_wr_i;
   assign mem_oe_o   = selected_o & ~rd_not_wr_i;
endmodule

// File: rtl/edac_feedthru.sv
module edac_feedthru #(
   parameter int         DATA_W     = 16,
   parameter int         CHK_W      = 6,
   parameter logic [5:0] ODD_MASK   = edac_pkg::ODD_GROUPS_DEF,
   parameter bit         SHARED_GEN = 1'b1,
   localparam int        BUS_W      = DATA_W + 1
) (
   input  logic [BUS_W-1:0] proc_data_i,
   input  logic [BUS_W-1:0] mem_data_i,
   input  logic [CHK_W-1:0] mem_chk_i,
   input  logic             rd_not_wr_i,
   input  logic             sel_a_n_i,
   input  logic             sel_b_n_i,
   input  logic             sel_c_i,
   input  logic             fix_en_i,
   input  logic             flag_en_i,
   input  logic             ext_fault_n_i,
   output logic [BUS_W-1:0] proc_data_o,
   output logic             proc_oe_o,
   output logic [BUS_W-1:0] mem_data_o,
   output logic [CHK_W-1:0] mem_chk_o,
   output logic             mem_oe_o,
   output logic             fix_err_n_o,
   output logic             hard_err_n_o
);
   // Parameter checks at elaboration.
   if (CHK_W != edac_pkg::CODE_CHK_W) begin : g_bad_chk
      $error("edac_feedthru: CHK_W must match the packaged code width");
   end
   if (DATA_W < 2 || DATA_W > edac_pkg::CODE_MAX_DATA) begin : g_bad_data
      $error("edac_feedthru: DATA_W out of range for the packaged code");
   end

   logic [CHK_W-1:0]  syn;
   logic [DATA_W-1:0] fixed;
   logic              col_hit, selected;

   // Write path: data and parity go straight through; check bits are generated.
   assign mem_data_o = proc_data_i;

   edac_chkgen #(.DATA_W(DATA_W), .CHK_W(CHK_W), .ODD_MASK(ODD_MASK)) u_gen (
      .data_i (proc_data_i[DATA_W-1:0]),
      .chk_o  (mem_chk_o)
   );

   // Read path: syndrome, then repair.
   edac_syndrome #(.DATA_W(DATA_W), .CHK_W(CHK_W), .ODD_MASK(ODD_MASK),
                   .SHARED_GEN(SHARED_GEN)) u_syn (
      .data_i (mem_data_i[DATA_W-1:0]),
      .chk_i  (mem_chk_i),
      .syn_o  (syn)
   );

   edac_corrector #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_fix (
      .data_i    (mem_data_i[DATA_W-1:0]),
      .syn_i     (syn),
      .fix_en_i  (fix_en_i),
      .data_o    (fixed),
      .col_hit_o (col_hit)
   );

   assign proc_data_o = {mem_data_i[DATA_W], fixed};

   edac_busctl u_bus (
      .sel_a_n_i   (sel_a_n_i),
      .sel_b_n_i   (sel_b_n_i),
      .sel_c_i     (sel_c_i),
      .rd_not_wr_i (rd_not_wr_i),
      .selected_o  (selected),
      .proc_oe_o   (proc_oe_o),
      .mem_oe_o    (mem_oe_o)
   );

   // Flags are gated by flag enable and select only, never by direction.
   edac_flags #(.CHK_W(CHK_W)) u_flg (
      .syn_i         (syn),
      .col_hit_i     (col_hit),
      .flag_on_i     (flag_en_i & selected),
      .ext_fault_n_i (ext_fault_n_i),
      .fix_err_n_o   (fix_err_n_o),
      .hard_err_n_o  (hard_err_n_o)
   );
endmodule

// File: rtl/edac_feedthru_chk.sv
module edac_feedthru_chk #(
   parameter int  DATA_W = 16,
   parameter int  CHK_W  = 6,
   localparam int BUS_W  = DATA_W + 1
) (
   input logic [BUS_W-1:0] proc_data_i,
   input logic [BUS_W-1:0] mem_data_i,
   input logic [CHK_W-1:0] mem_chk_i,
   input logic             rd_not_wr_i,
   input logic             sel_a_n_i,
   input logic             sel_b_n_i,
   input logic             sel_c_i,
   input logic             fix_en_i,
   input logic             flag_en_i,
   input logic             ext_fault_n_i,
   input logic [BUS_W-1:0] proc_data_o,
   input logic             proc_oe_o,
   input logic [BUS_W-1:0] mem_data_o,
   input logic [CHK_W-1:0] mem_chk_o,
   input logic             mem_oe_o,
   input logic             fix_err_n_o,
   input logic             hard_err_n_o
);
   logic known, picked, loopback;

   assign known    = !$isunknown({proc_data_i, mem_data_i, mem_chk_i, rd_not_wr_i, sel_a_n_i,
                                  sel_b_n_i, sel_c_i, fix_en_i, flag_en_i, ext_fault_n_i});
   assign picked   = !sel_a_n_i && !sel_b_n_i && sel_c_i;
   assign loopback = (mem_data_i == mem_data_o) && (mem_chk_i == mem_chk_o);

   always_comb begin
      if (known) begin
         AST_PARITY_PASS: assert (proc_data_o[DATA_W] == mem_data_i[DATA_W] && mem_data_o[DATA_W] == proc_data_i[DATA_W]); // R1
         AST_CLEAN_LOOP: assert (!(loopback && ext_fault_n_i) || (fix_err_n_o && hard_err_n_o && proc_data_o == mem_data_i)); // R2
         AST_FIX_FLAGGED: assert (proc_data_o[DATA_W-1:0] == mem_data_i[DATA_W-1:0] || !flag_en_i || !picked || !fix_err_n_o); // R3
         AST_AT_MOST_ONE: assert ($countones(proc_data_o[DATA_W-1:0] ^ mem_data_i[DATA_W-1:0]) <= 1); // R4
         AST_RAW_WHEN_OFF: assert (fix_en_i || proc_data_o[DATA_W-1:0] == mem_data_i[DATA_W-1:0]); // R5
         AST_FLAGS_QUIET: assert ((flag_en_i && picked) || (fix_err_n_o && hard_err_n_o == ext_fault_n_i)); // R7
         AST_EXT_FORCE: assert (ext_fault_n_i || !hard_err_n_o); // R8
         AST_OE_EXCL: assert (!(proc_oe_o && mem_oe_o) && (picked || (!proc_oe_o && !mem_oe_o))); // R9
      end
   end
endmodule

bind edac_feedthru edac_feedthru_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (
   .proc_data_i   (proc_data_i),
   .mem_data_i    (mem_data_i),
   .mem_chk_i     (mem_chk_i),
   .rd_not_wr_i   (rd_not_wr_i),
   .sel_a_n_i     (sel_a_n_i),
   .sel_b_n_i     (sel_b_n_i),
   .sel_c_i       (sel_c_i),
   .fix_en_i      (fix_en_i),
   .flag_en_i     (flag_en_i),
   .ext_fault_n_i (ext_fault_n_i),
   .proc_data_o   (proc_data_o),
   .proc_oe_o     (proc_oe_o),
   .mem_data_o    (mem_data_o),
   .mem_chk_o     (mem_chk_o),
   .mem_oe_o      (mem_oe_o),
   .fix_err_n_o   (fix_err_n_o),
   .hard_err_n_o  (hard_err_n_o)
);

// File: tb/sim_edac_feedthru.sv
module sim_edac_feedthru;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic [16:0] pd_i, md_i, pd_o, md_o;
   logic [5:0]  cb_i, cb_o;
   logic rd, a_n, b_n, c, fix_en, flg_en, ext_n;
   logic poe, moe, fix_n, hard_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [15:0] d, bad_d;
   logic [21:0] e;
   logic        par;

   edac_feedthru u0 (
      .proc_data_i (pd_i), .mem_data_i (md_i), .mem_chk_i (cb_i),
      .rd_not_wr_i (rd), .sel_a_n_i (a_n), .sel_b_n_i (b_n), .sel_c_i (c),
      .fix_en_i (fix_en), .flag_en_i (flg_en), .ext_fault_n_i (ext_n),
      .proc_data_o (pd_o), .proc_oe_o (poe), .mem_data_o (md_o), .mem_chk_o (cb_o),
      .mem_oe_o (moe), .fix_err_n_o (fix_n), .hard_err_n_o (hard_n)
   );

   // Reference code: columns are the weight-3 6-bit values in rising order, minus 7, 25, 38, 56.
   function automatic logic [5:0] m_col(input int idx);
      int cnt = 0;
      for (int v = 0; v < 64; v++) begin
         if ($countones(6'(v)) == 3 && v != 7 && v != 25 && v != 38 && v != 56) begin
            if (cnt == idx) return 6'(v);
            cnt++;
         end
      end
      return 6'd0;
   endfunction

   function automatic logic [5:0] m_chk(input logic [15:0] dv);
      logic [5:0] r = 6'b001100;
      for (int i = 0; i < 16; i++) if (dv[i]) r = r ^ m_col(i);
      return r;
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic ctl(input logic r, input logic an, input logic bn, input logic cc,
                      input logic fe, input logic fl, input logic ex);
      rd = r; a_n = an; b_n = bn; c = cc; fix_en = fe; flg_en = fl; ext_n = ex;
   endtask

   // Memory word with error vector ev: bits 15:0 data, bits 21:16 check.
   task automatic mem_word(input logic [15:0] dv, input logic [21:0] ev, input logic p);
      md_i = {p, dv ^ ev[15:0]};
      cb_i = m_chk(dv) ^ ev[21:16];
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      pd_i = '0; md_i = '0; cb_i = '0;
      ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // Idle state: deselected, quiet.
      check("R9", "idle poe", {31'd0, poe}, 32'd0);
      check("R9", "idle moe", {31'd0, moe}, 32'd0);
      check("R7", "idle flags", {30'd0, fix_n, hard_n}, 32'd3);

      // R2 R10: exhaustive write sweep with loop-back memory bus.
      ctl(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
      for (int v = 0; v < 65536; v++) begin
         pd_i = {^v[3:0], v[15:0]};
         md_i = pd_i;
         cb_i = m_chk(v[15:0]);
         @(negedge clk);
         check("R2", "write data", {15'd0, md_o}, {15'd0, pd_i});
         check("R2", "write check", {26'd0, cb_o}, {26'd0, cb_i});
         if (v % 256 == 0) begin
            check("R10", "clean write flags", {30'd0, fix_n, hard_n}, 32'd3);
            check("R9", "write oe", {30'd0, poe, moe}, 32'd1);
         end
      end
      // R10: check-bit fault during a write still flags.
      cb_i = m_chk(16'h00ff) ^ 6'b000100;
      pd_i = 17'h000ff; md_i = pd_i;
      @(negedge clk);
      check("R10", "write fault flags", {30'd0, fix_n, hard_n}, 32'd1);

      // R1 R3 R4 R5: every single-bit fault on a range of words.
      ctl(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
      for (int k = 0; k < 48; k++) begin
         d   = 16'(k * 16'h3b1d + 16'h1234);
         par = k[0];
         mem_word(d, 22'd0, par);
         check("R3", "clean flags", {30'd0, fix_n, hard_n}, 32'd3);
         check("R1", "parity up", {31'd0, pd_o[16]}, {31'd0, par});
         for (int b = 0; b < 22; b++) begin
            e = 22'd1 << b;
            fix_en = 1'b1;
            mem_word(d, e, par);
            check("R4", "single fix data", {15'd0, pd_o}, {15'd0, par, d});
            check("R3", "single flags", {30'd0, fix_n, hard_n}, 32'd1);
            fix_en = 1'b0;
            mem_word(d, e, par);
            bad_d = d ^ e[15:0];
            check("R5", "raw data", {16'd0, pd_o[15:0]}, {16'd0, bad_d});
         end
      end

      // R6: every double fault on a few words.
      fix_en = 1'b1;
      for (int k = 0; k < 4; k++) begin
         d = 16'(k * 16'h5a3c + 16'h0f0f);
         for (int a = 0; a < 22; a++)
            for (int b = a + 1; b < 22; b++) begin
               e = (22'd1 << a) | (22'd1 << b);
               mem_word(d, e, 1'b0);
               check("R6", "double flags", {30'd0, fix_n, hard_n}, 32'd2);
            end
      end

      // R11: triple check faults on the unused weight-3 patterns.
      d = 16'hc3a5;
      mem_word(d, {6'd7, 16'd0}, 1'b1);
      check("R11", "spare 7 flags", {30'd0, fix_n, hard_n}, 32'd0);
      check("R11", "spare 7 data", {16'd0, pd_o[15:0]}, {16'd0, d});
      mem_word(d, {6'd25, 16'd0}, 1'b1);
      check("R11", "spare 25 flags", {30'd0, fix_n, hard_n}, 32'd0);
      mem_word(d, {6'd38, 16'd0}, 1'b1);
      check("R11", "spare 38 data", {16'd0, pd_o[15:0]}, {16'd0, d});
      mem_word(d, {6'd56, 16'd0}, 1'b1);
      check("R11", "spare 56 flags", {30'd0, fix_n, hard_n}, 32'd0);

      // R7 R8 R9 R10: full control sweep with one data fault present.
      for (int cv = 0; cv < 64; cv++) begin
         logic sel;
         ctl(cv[0], cv[1], cv[2], cv[3], 1'b1, cv[4], cv[5]);
         sel = !cv[1] && !cv[2] && cv[3];
         mem_word(16'h7e81, 22'h000400, 1'b0);
         check("R9", "oe pair", {30'd0, poe, moe}, {30'd0, sel && cv[0], sel && !cv[0]});
         check("R7", "fix flag", {31'd0, fix_n}, {31'd0, !(sel && cv[4])});
         check("R8", "hard flag", {31'd0, hard_n}, {31'd0, cv[5]});
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule